// File: doc/BRIEF.md
# Memory-Mapped Multi-Comparator Event Timer

This block keeps a free-running main counter and a small set of comparator channels, all reached through a plain 32-bit register port made of an address, a write strobe and write data. Read data returns one clock after the address is presented. Each comparator has its own interrupt line. Software can start and stop the counter, reload it while it is stopped, and program each comparator to fire once or at a fixed rate.

A channel fires when the counter equals the channel's programmed value. When it fires, it sets its bit in a shared status word. Its interrupt line then either follows that bit (level mode) or pulses for one clock (edge mode). In periodic mode, the channel adds its last programmed period to its own target at every match. A self-clearing gate bit decides whether a write to the target reloads the running value or only updates the period. Channels without 64-bit support, or with 32-bit operation forced, compare only the low 32 counter bits. Such channels ignore writes to the upper word of their target.

Top module: `evt_timer_top`

## Requirements
- R1: After reset, the following hold. The capability word at 0x000 reads {16'h0, bit15=1 (legacy routing supported), bit14=0, bit13=64-bit counter, bits12:8=channels-1, 8'h01}, which is 0x0000A201 with the default parameters. The word at 0x004 reads the tick period in femtoseconds (0x00989680 by default). The global configuration at 0x010 reads 0. The counter reads 0. All interrupt outputs are low. The channel configuration words read only their capability bits: bit4 = periodic supported, bit5 = 64-bit supported. By default these read 0x30, 0x10 and 0x00 for channels 0 to 2.
- R2: Bit 0 of the global configuration at 0x010 is the run enable. While it is 1, the counter at 0xF0 (low word) and 0xF4 (high word) increases by exactly one per clock. While it is 0, the counter holds its value.
- R3: Writes to 0xF0 or 0xF4 load the counter only while the run enable is 0. While the counter runs, such writes are ignored.
- R4: Channel n's registers sit at 0x100+0x20*n: configuration at +0x0, route bitmap at +0x4, target low word at +0x8 and target high word at +0xC. In the configuration word, bit1 selects level mode and bit2 enables the interrupt. When the running counter equals the target, the channel sets bit n of the status word at 0x020. In level mode, the channel's interrupt output rises on the second clock edge after the matching count and stays high while the status bit and the enable are both 1. Writing 1 to bit n of 0x020 clears the bit and drops the line. With bit2 at 0, the status bit is still set but the line stays low.
- R5: In edge mode (bit1 = 0), a match produces a one-clock interrupt pulse on the second clock edge after the matching count.
- R6: Bit3 of the configuration word selects periodic mode. In periodic mode, a target write with the gate bit6 set loads both the running target and the period. A target write with bit6 clear updates only the period. At every match, the period is added to the running target, so matches repeat every period.
- R7: The gate bit6 clears by itself after any accepted target-word write and then reads 0. Each further target write that should load the running target needs bit6 set again.
- R8: A channel runs in 32-bit mode when it lacks 64-bit support or when bit8 is set. In 32-bit mode, writes to the high target word are ignored and that word reads 0. Matches compare only the low 32 counter bits, so a match is found after the low half wraps.
- R9: The capability bits 4 and 5 are read-only. Bit3 (periodic) can be set only on a channel that supports periodic mode. Bit8 can be set only on a channel that supports 64-bit mode.
- R10: With the 64-bit counter option, a carry out of the low word increments the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Byte address of the 32-bit register |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_out | output | NUM_CMP | One interrupt line per comparator channel |

## Verification
The assertions assume that the register address and write strobe are clean (never X) once reset is released. They also assume that a write to a target word is never paired, in the same cycle, with a write to that channel's configuration word. Both hold by construction of the port, which decodes a single address per cycle. The stimulus drives every input at the falling clock edge and issues at most one register access per clock. It also stops the counter before reloading it, except where a write during counting is the point of the test.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;
  // global register byte addresses
  localparam logic [11:0] A_CAP  = 12'h000;
  localparam logic [11:0] A_PRD  = 12'h004;
  localparam logic [11:0] A_GCFG = 12'h010;
  localparam logic [11:0] A_STS  = 12'h020;
  localparam logic [11:0] A_CLO  = 12'h0F0;
  localparam logic [11:0] A_CHI  = 12'h0F4;

  // channel blocks start at 0x100, 32 bytes each: block index = addr[11:5]
  localparam int CH_BLK0 = 8;

  // word index inside a channel block (addr[4:2])
  localparam logic [2:0] W_CFG = 3'd0;
  localparam logic [2:0] W_RT  = 3'd1;
  localparam logic [2:0] W_VLO = 3'd2;
  localparam logic [2:0] W_VHI = 3'd3;

  // channel configuration bit positions
  localparam int B_LVL  = 1;
  localparam int B_IE   = 2;
  localparam int B_PER  = 3;
  localparam int B_PCAP = 4;
  localparam int B_W64  = 5;
  localparam int B_VSET = 6;
  localparam int B_F32  = 8;
  localparam int B_RT   = 9;
  localparam int RT_W   = 5;

  typedef struct packed {
    logic [RT_W-1:0] route;
    logic            f32;
    logic            vset;
    logic            per;
    logic            ie;
    logic            lvl;
  } tcfg_t;

  function automatic logic [11:0] ch_addr(input int ch, input logic [2:0] w);
    return 12'(256 + 32 * ch + 4 * int'(w));
  endfunction
endpackage

// File: rtl/evt_main_counter.sv
`timescale 1ns/1ps
module evt_main_counter #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [31:0]   wdata,
  output logic [CW-1:0] cnt
);
  generate
    if (CW > 32) begin : g_wide
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt <= '0;
        end else if (run) begin
          cnt <= cnt + 1'b1;
        end else begin
          if (ld_lo) cnt[31:0]    <= wdata;
          if (ld_hi) cnt[CW-1:32] <= wdata[CW-33:0];
        end
      end
    end else begin : g_narrow
      wire unused_hi = ld_hi;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt <= '0;
        end else if (run) begin
          cnt <= cnt + 1'b1;
        end else if (ld_lo) begin
          cnt <= wdata[CW-1:0];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/evt_comparator.sv
`timescale 1ns/1ps
module evt_comparator
  import evt_pkg::*;
#(
  parameter bit CAN64  = 1'b1,
  parameter bit CANPER = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        run,
  input  logic [63:0] cnt,
  input  logic        wr_cfg,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        sts_clr,
  output logic [31:0] cfg_rd,
  output logic [31:0] val_lo_rd,
  output logic [31:0] val_hi_rd,
  output logic        hit,
  output logic        sts,
  output logic        irq,
  output logic        vset_o,
  output logic        mode32_o,
  output logic [31:0] acc_hi_q
);
  tcfg_t       c;
  logic [63:0] acc;
  logic [63:0] prd;
  logic        mode32;
  logic        eq;
  logic        sts_d;
  logic        load_ok;

  assign mode32  = !CAN64 || c.f32;
  assign eq      = mode32 ? (acc[31:0] == cnt[31:0]) : (acc == cnt);
  assign hit     = run && eq;
  assign sts_d   = hit | (sts & ~sts_clr);
  assign load_ok = !c.per || c.vset;

  always_ff @(posedge clk) begin
    if (rst) begin
      c   <= '0;
      acc <= '0;
      prd <= '0;
      sts <= 1'b0;
      irq <= 1'b0;
    end else begin
      sts <= sts_d;
      irq <= c.lvl ? (c.ie & sts_d) : (c.ie & hit);
      if (wr_cfg) begin
        c.lvl   <= wdata[B_LVL];
        c.ie    <= wdata[B_IE];
        c.per   <= CANPER ? wdata[B_PER] : 1'b0;
        c.vset  <= wdata[B_VSET];
        c.f32   <= CAN64 ? wdata[B_F32] : 1'b0;
        c.route <= wdata[B_RT +: RT_W];
      end
      if (wr_lo) begin
        prd[31:0] <= wdata;
        if (load_ok) acc[31:0] <= wdata;
        c.vset <= 1'b0;
      end else if (wr_hi && !mode32) begin
        prd[63:32] <= wdata;
        if (load_ok) acc[63:32] <= wdata;
        c.vset <= 1'b0;
      end else if (hit && c.per) begin
        if (mode32) acc[31:0] <= acc[31:0] + prd[31:0];
        else        acc       <= acc + prd;
      end
    end
  end

  always_comb begin
    cfg_rd             = '0;
    cfg_rd[B_LVL]      = c.lvl;
    cfg_rd[B_IE]       = c.ie;
    cfg_rd[B_PER]      = c.per;
    cfg_rd[B_PCAP]     = CANPER;
    cfg_rd[B_W64]      = CAN64;
    cfg_rd[B_VSET]     = c.vset;
    cfg_rd[B_F32]      = c.f32;
    cfg_rd[B_RT +: RT_W] = c.route;
  end

  assign val_lo_rd = acc[31:0];
  assign val_hi_rd = mode32 ? 32'h0 : acc[63:32];
  assign vset_o    = c.vset;
  assign mode32_o  = mode32;
  assign acc_hi_q  = acc[63:32];
endmodule

// File: rtl/evt_timer_top.sv
`timescale 1ns/1ps
module evt_timer_top
  import evt_pkg::*;
#(
  parameter int          NUM_CMP   = 3,
  parameter int          CNT64     = 1,
  parameter logic [31:0] PERIOD_FS = 32'h0098_9680,
  parameter logic [31:0] CMP_W64   = 32'h0000_0001,
  parameter logic [31:0] CMP_PER   = 32'h0000_0003,
  parameter logic [31:0] ROUTE_MAP = 32'h00F0_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [11:0]        reg_addr,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [NUM_CMP-1:0] irq_out
);
  localparam int CW = (CNT64 != 0) ? 64 : 32;
  localparam logic [31:0] CAP_WORD = 32'h0000_8001
                                   | ((CNT64 != 0) ? 32'h0000_2000 : 32'h0)
                                   | (32'((NUM_CMP - 1) & 31) << 8);

  logic          run;
  logic          legacy;
  logic [CW-1:0] cnt;
  logic [63:0]   cnt64;
  logic          wr_sts;

  logic [NUM_CMP-1:0]    hit_v, sts_v, vset_v, mode32_v;
  logic [NUM_CMP*32-1:0] acchi_v;
  logic [31:0]           cfg_a [NUM_CMP];
  logic [31:0]           lo_a  [NUM_CMP];
  logic [31:0]           hi_a  [NUM_CMP];
  logic [31:0]           rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      legacy <= 1'b0;
    end else if (reg_wr && reg_addr == A_GCFG) begin
      run    <= reg_wdata[0];
      legacy <= reg_wdata[1];
    end
  end

  evt_main_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .ld_lo (reg_wr && reg_addr == A_CLO),
    .ld_hi (reg_wr && reg_addr == A_CHI),
    .wdata (reg_wdata),
    .cnt   (cnt)
  );

  assign cnt64  = 64'(cnt);
  assign wr_sts = reg_wr && reg_addr == A_STS;

  generate
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_ch
      logic blk;
      assign blk = reg_addr[11:5] == 7'(CH_BLK0 + i);
      evt_comparator #(.CAN64(CMP_W64[i]), .CANPER(CMP_PER[i])) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .cnt       (cnt64),
        .wr_cfg    (reg_wr && blk && reg_addr[4:2] == W_CFG),
        .wr_lo     (reg_wr && blk && reg_addr[4:2] == W_VLO),
        .wr_hi     (reg_wr && blk && reg_addr[4:2] == W_VHI),
        .wdata     (reg_wdata),
        .sts_clr   (wr_sts && reg_wdata[i]),
        .cfg_rd    (cfg_a[i]),
        .val_lo_rd (lo_a[i]),
        .val_hi_rd (hi_a[i]),
        .hit       (hit_v[i]),
        .sts       (sts_v[i]),
        .irq       (irq_out[i]),
        .vset_o    (vset_v[i]),
        .mode32_o  (mode32_v[i]),
        .acc_hi_q  (acchi_v[i*32 +: 32])
      );
    end
  endgenerate

  wire unused_obs = ^{hit_v, vset_v, mode32_v, acchi_v};

  always_comb begin
    rd_d = '0;
    case (reg_addr)
      A_CAP:   rd_d = CAP_WORD;
      A_PRD:   rd_d = PERIOD_FS;
      A_GCFG:  rd_d = {30'h0, legacy, run};
      A_STS:   rd_d = 32'(sts_v);
      A_CLO:   rd_d = cnt64[31:0];
      A_CHI:   rd_d = cnt64[63:32];
      default: rd_d = '0;
    endcase
    for (int i = 0; i < NUM_CMP; i++) begin
      if (reg_addr[11:5] == 7'(CH_BLK0 + i)) begin
        case (reg_addr[4:2])
          W_CFG:   rd_d = cfg_a[i];
          W_RT:    rd_d = ROUTE_MAP;
          W_VLO:   rd_d = lo_a[i];
          W_VHI:   rd_d = hi_a[i];
          default: rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end
endmodule

// File: rtl/evt_timer_chk.sv
`timescale 1ns/1ps
module evt_timer_chk
  import evt_pkg::*;
#(
  parameter int NUM_CMP = 3,
  parameter int CW      = 64
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_wr,
  input logic [11:0]           reg_addr,
  input logic                  run,
  input logic [CW-1:0]         cnt,
  input logic [NUM_CMP-1:0]    hit_v,
  input logic [NUM_CMP-1:0]    sts_v,
  input logic [NUM_CMP-1:0]    vset_v,
  input logic [NUM_CMP-1:0]    mode32_v,
  input logic [NUM_CMP*32-1:0] acchi_v
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    run |=> cnt == CW'($past(cnt) + 1'b1)); // R2

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !(reg_wr && (reg_addr == A_CLO || reg_addr == A_CHI))) |=> $stable(cnt)); // R2

  AST_RUN_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (run && reg_wr && reg_addr == A_CLO) |=> cnt == CW'($past(cnt) + 1'b1)); // R3

  generate
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_ch
      AST_VSET_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ch_addr(i, W_VLO)) |=> !vset_v[i]); // R7

      AST_MATCH_SETS_STS: assert property (@(posedge clk) disable iff (rst)
        hit_v[i] |=> sts_v[i]); // R4

      AST_HI_WORD_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (mode32_v[i] && reg_wr && reg_addr == ch_addr(i, W_VHI))
          |=> $stable(acchi_v[i*32 +: 32])); // R8
    end
  endgenerate
endmodule

bind evt_timer_top evt_timer_chk #(.NUM_CMP(NUM_CMP), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .run      (run),
  .cnt      (cnt),
  .hit_v    (hit_v),
  .sts_v    (sts_v),
  .vset_v   (vset_v),
  .mode32_v (mode32_v),
  .acchi_v  (acchi_v)
);

// File: tb/sim_evt_timer_top.sv
`timescale 1ns/1ps
module sim_evt_timer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;
  int          n_chk = 0;
  int          n_err = 0;

  always #2.5 clk = ~clk;

  evt_timer_top u0 (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (addr),
    .reg_wr    (we),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .irq_out   (irq)
  );

  function automatic logic [11:0] ca(input int ch, input int w);
    return 12'(256 + 32 * ch + 4 * w);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_irq(input int ch, output int n);
    n = 0;
    while (!irq[ch] && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic stop_and_load(input logic [31:0] lo, input logic [31:0] hi);
    wr(12'h010, 32'h0);
    wr(12'h0F0, lo);
    wr(12'h0F4, hi);
    wr(12'h020, 32'h7);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(irq == 3'b000, "R1 irq after reset", 64'(irq), 0);
    rd(12'h000, v); chk(v == 32'h0000_A201, "R1 capability word", v, 32'h0000_A201);
    rd(12'h004, v); chk(v == 32'h0098_9680, "R1 tick period", v, 32'h0098_9680);
    rd(12'h010, v); chk(v == 32'h0, "R1 global cfg", v, 0);
    rd(12'h0F0, v); chk(v == 32'h0, "R1 counter low", v, 0);
    rd(ca(0, 0), v); chk(v == 32'h30, "R1 ch0 cfg caps", v, 32'h30);
    rd(ca(1, 0), v); chk(v == 32'h10, "R1 ch1 cfg caps", v, 32'h10);
    rd(ca(2, 0), v); chk(v == 32'h00, "R1 ch2 cfg caps", v, 32'h00);
  endtask

  task automatic t_counter;
    logic [31:0] a, b;
    stop_and_load(32'h100, 32'h0);
    rd(12'h0F0, a); chk(a == 32'h100, "R3 load while stopped", a, 32'h100);
    wr(12'h010, 32'h1);
    rd(12'h0F0, a); rd(12'h0F0, b);
    chk(b - a == 32'd2, "R2 one step per clock", b - a, 2);
    wr(12'h0F0, 32'h0);
    rd(12'h0F0, a); chk(a > 32'h100, "R3 low write ignored while running", a, 32'h101);
    wr(12'h0F4, 32'h5);
    rd(12'h0F4, a); chk(a == 32'h0, "R3 high write ignored while running", a, 0);
    wr(12'h010, 32'h0);
    rd(12'h0F0, a); rd(12'h0F0, b);
    chk(a == b, "R2 counter holds when disabled", b, a);
    stop_and_load(32'hFFFF_FFFE, 32'h0);
    wr(12'h010, 32'h1);
    repeat (5) @(negedge clk);
    wr(12'h010, 32'h0);
    rd(12'h0F4, a); chk(a == 32'h1, "R10 carry into high word", a, 1);
  endtask

  task automatic t_caps;
    logic [31:0] v;
    wr(ca(2, 0), 32'h38);
    rd(ca(2, 0), v); chk(v == 32'h00, "R9 periodic refused on ch2", v, 0);
    wr(ca(0, 0), 32'h38);
    rd(ca(0, 0), v); chk(v == 32'h38, "R9 periodic accepted on ch0", v, 32'h38);
    wr(ca(1, 0), 32'h100);
    rd(ca(1, 0), v); chk(v == 32'h10, "R9 force32 not storable on ch1", v, 32'h10);
    wr(ca(0, 0), 32'h0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    int n;
    stop_and_load(32'h0, 32'h0);
    wr(ca(0, 0), 32'h6);
    wr(ca(0, 2), 32'd50);
    wr(ca(0, 3), 32'h0);
    wr(ca(2, 0), 32'h2);
    wr(ca(2, 2), 32'd50);
    wr(12'h020, 32'h7);
    wr(12'h010, 32'h1);
    wait_irq(0, n);
    chk(n == 51, "R4 level irq timing", n, 51);
    chk(irq[2] == 1'b0, "R4 no irq without enable", 64'(irq[2]), 0);
    rd(12'h020, v);
    chk(v[0] == 1'b1, "R4 status set ch0", v, 1);
    chk(v[2] == 1'b1, "R4 status set ch2", v, 4);
    chk(irq[0] == 1'b1, "R4 level irq held", 64'(irq[0]), 1);
    wr(12'h020, 32'h1);
    chk(irq[0] == 1'b0, "R4 irq drops on clear", 64'(irq[0]), 0);
    rd(12'h020, v); chk(v[0] == 1'b0, "R4 status cleared", v[0], 0);
    wr(12'h010, 32'h0);
    wr(ca(2, 0), 32'h0);
  endtask

  task automatic t_edge;
    int n;
    stop_and_load(32'h0, 32'h0);
    wr(ca(0, 0), 32'h4);
    wr(ca(0, 2), 32'd20);
    wr(12'h010, 32'h1);
    wait_irq(0, n);
    chk(n == 21, "R5 edge pulse timing", n, 21);
    @(negedge clk);
    chk(irq[0] == 1'b0, "R5 pulse lasts one clock", 64'(irq[0]), 0);
    wr(12'h010, 32'h0);
  endtask

  task automatic t_periodic;
    logic [31:0] v, a;
    int n, m;
    stop_and_load(32'h0, 32'h0);
    wr(ca(0, 0), 32'h4C);
    rd(ca(0, 0), v); chk(v[6] == 1'b1, "R7 gate bit set", v, 32'h7C);
    wr(ca(0, 2), 32'd30);
    rd(ca(0, 0), v); chk(v[6] == 1'b0, "R7 gate clears after low write", v, 32'h3C);
    wr(ca(0, 0), 32'h4C);
    wr(ca(0, 3), 32'h0);
    rd(ca(0, 0), v); chk(v[6] == 1'b0, "R7 gate clears after high write", v, 32'h3C);
    rd(ca(0, 2), v); chk(v == 32'd30, "R6 gated write loads target", v, 30);
    wr(12'h010, 32'h1);
    wait_irq(0, n);
    chk(n == 31, "R6 first periodic match", n, 31);
    for (int k = 0; k < 2; k++) begin
      m = 0;
      do begin
        @(negedge clk);
        m++;
      end while (!irq[0] && m < 400);
      chk(m == 30, "R6 period between matches", m, 30);
    end
    wr(12'h010, 32'h0);
    rd(ca(0, 2), a);
    wr(ca(0, 2), 32'd7);
    rd(ca(0, 2), v); chk(v == a, "R6 ungated write keeps target", v, a);
    wr(ca(0, 0), 32'h0);
  endtask

  task automatic t_narrow;
    logic [31:0] v;
    int n;
    wr(ca(1, 3), 32'h1234);
    rd(ca(1, 3), v); chk(v == 32'h0, "R8 high ignored on 32-bit channel", v, 0);
    wr(ca(0, 0), 32'h100);
    wr(ca(0, 3), 32'h55);
    rd(ca(0, 3), v); chk(v == 32'h0, "R8 high ignored when forced 32", v, 0);
    rd(ca(0, 0), v); chk(v == 32'h130, "R8 force bit reads back", v, 32'h130);
    wr(ca(0, 0), 32'h0);
    stop_and_load(32'hFFFF_FFF8, 32'h0);
    wr(ca(1, 0), 32'h6);
    wr(ca(1, 2), 32'd4);
    wr(12'h020, 32'h7);
    wr(12'h010, 32'h1);
    wait_irq(1, n);
    chk(n == 13, "R8 low-half compare after wrap", n, 13);
    wr(12'h010, 32'h0);
    wr(ca(1, 0), 32'h0);
    wr(12'h020, 32'h7);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_counter();
    t_caps();
    t_oneshot();
    t_edge();
    t_periodic();
    t_narrow();
    report();
  end
endmodule